// File: doc/BRIEF.md
# Flowlet Next-Hop Table

This block keeps packets of one flow on the same path while they arrive in a burst, and lets the flow move to a new path after a quiet period. Each arriving packet carries a source port, a destination port, an arrival timestamp and a proposed next hop chosen by an upstream balancer. The two ports are folded by XOR into an index into a small table. Each table entry holds the time the entry was last hit and the hop that was last granted to it.

For each packet the block reads the entry, subtracts the stored time from the arrival time, and compares the result with a fixed gap limit. If the gap is strictly larger, the burst is over: the proposed hop is stored and sent out. Otherwise the stored hop is sent out and the entry keeps it. In both cases the arrival time replaces the stored time. The read, the compare and both writes finish in one clock cycle, so a packet can be accepted every cycle and a packet that hits the same entry one cycle later sees the new values. The chosen hop is registered and appears one cycle after the packet is accepted.

Top module: `flowlet_hop_table`

## Requirements
- R1: The entry index is a 6-bit XOR fold of the 32-bit key {src_port, dst_port} (source in key bits 31:16). Index bit b is the XOR of every key bit k with k mod 6 == b. Packets whose keys fold to the same index share one entry.
- R2: out_valid is high in the cycle after a cycle with in_valid high, and low in the cycle after a cycle with in_valid low.
- R3: When (arrival - stored time) mod 2^32 is strictly greater than GAP_LIMIT (default 100), the entry's hop becomes in_new_hop and out_hop carries in_new_hop.
- R4: When the gap is less than or equal to GAP_LIMIT, including exactly equal, the entry's hop is unchanged and out_hop carries the stored hop.
- R5: Every accepted packet writes its arrival time into its entry's stored time, whether or not the hop changes.
- R6: Packets on consecutive cycles that hit the same entry are handled as if processed one at a time: the second sees the time and hop written by the first.
- R7: Reset clears every stored time and stored hop to zero and drives out_valid low.
- R8: The gap is computed modulo 2^32, so an arrival time that has wrapped past zero gives a small gap.
- R9: A cycle with in_valid low changes no entry, and a packet changes no entry other than its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Packet present this cycle |
| in_src_port | input | 16 | Source port of the packet |
| in_dst_port | input | 16 | Destination port of the packet |
| in_arrival | input | 32 | Arrival timestamp |
| in_new_hop | input | 8 | Proposed next hop |
| out_valid | output | 1 | Chosen hop valid |
| out_hop | output | 8 | Next hop to use |

## Verification
Every result of this block is due exactly one clock edge after the packet is presented: out_valid and out_hop are registered from the same edge that writes the table. The bench drives each packet on a falling edge and reads the outputs at the next falling edge, one edge after the one that captured the packet. Effects on table state are observed through later packets, whose outputs follow the same one-cycle rule. Back-to-back packets are driven on consecutive falling edges, so each is checked one edge after the table update it depends on.

// File: rtl/flowlet_pkg.sv
package flowlet_pkg;
  // Default geometry shared by the table and its bench.
  localparam int unsigned DEF_ENTRIES   = 64;
  localparam int unsigned DEF_PORT_W    = 16;
  localparam int unsigned DEF_TS_W      = 32;
  localparam int unsigned DEF_HOP_W     = 8;
  localparam int unsigned DEF_GAP_LIMIT = 100;
endpackage

// File: rtl/flowlet_index_hash.sv
module flowlet_index_hash #(
  parameter int unsigned PORT_W  = 16,
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [PORT_W-1:0] src_port,
  input  logic [PORT_W-1:0] dst_port,
  output logic [IDX_W-1:0]  index
);
  localparam int unsigned KEY_W  = 2 * PORT_W;
  localparam int unsigned CHUNKS = (KEY_W + IDX_W - 1) / IDX_W;
  localparam int unsigned PAD_W  = CHUNKS * IDX_W;

  // XOR fold of the key into IDX_W-bit slices.
  function automatic logic [IDX_W-1:0] fold_key(input logic [KEY_W-1:0] key);
    logic [PAD_W-1:0] padded;
    logic [IDX_W-1:0] acc;
    padded = PAD_W'(key);
    acc    = '0;
    for (int c = 0; c < CHUNKS; c++) begin
      acc = acc ^ padded[c*IDX_W +: IDX_W];
    end
    return acc;
  endfunction

  logic [IDX_W-1:0] folded;

  always_comb begin
    folded = fold_key({src_port, dst_port});
    index  = IDX_W'(32'(folded) % ENTRIES);
  end
endmodule

// File: rtl/flowlet_state_store.sv
module flowlet_state_store #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned TS_W    = 32,
  parameter int unsigned HOP_W   = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] acc_idx,
  output logic [TS_W-1:0]  rd_time,
  output logic [HOP_W-1:0] rd_hop,
  input  logic             time_we,
  input  logic [TS_W-1:0]  wr_time,
  input  logic             hop_we,
  input  logic [HOP_W-1:0] wr_hop
);
  logic [TS_W-1:0]  last_time_q [ENTRIES];
  logic [HOP_W-1:0] saved_hop_q [ENTRIES];

  // Asynchronous read: the same cycle sees the value written at the last edge.
  assign rd_time = last_time_q[acc_idx];
  assign rd_hop  = saved_hop_q[acc_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        last_time_q[i] <= '0;
        saved_hop_q[i] <= '0;
      end
    end else begin
      if (time_we) last_time_q[acc_idx] <= wr_time;
      if (hop_we)  saved_hop_q[acc_idx] <= wr_hop;
    end
  end

  // R5: the arrival time lands in the addressed entry on every write.
  assert_time_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
    time_we |=> last_time_q[$past(acc_idx)] == $past(wr_time));

  // R4: without a hop write the addressed hop entry holds its value.
  assert_hop_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hop_we |=> saved_hop_q[$past(acc_idx)] == $past(rd_hop));
endmodule

// File: rtl/flowlet_gap_decide.sv
module flowlet_gap_decide #(
  parameter int unsigned TS_W      = 32,
  parameter int unsigned HOP_W     = 8,
  parameter int unsigned GAP_LIMIT = 100
) (
  input  logic [TS_W-1:0]  arrival,
  input  logic [TS_W-1:0]  last_time,
  input  logic [HOP_W-1:0] stored_hop,
  input  logic [HOP_W-1:0] proposed_hop,
  output logic             take_new,
  output logic [HOP_W-1:0] chosen_hop
);
  localparam logic [TS_W-1:0] LIMIT = TS_W'(GAP_LIMIT);

  // Inter-arrival gap, modulo 2^TS_W so a wrapped clock still gives a small gap.
  function automatic logic [TS_W-1:0] modular_gap(input logic [TS_W-1:0] now_t,
                                                  input logic [TS_W-1:0] then_t);
    return now_t - then_t;
  endfunction

  logic [TS_W-1:0] gap;

  always_comb begin
    gap        = modular_gap(arrival, last_time);
    take_new   = gap > LIMIT;
    chosen_hop = take_new ? proposed_hop : stored_hop;
  end
endmodule

// File: rtl/flowlet_hop_table.sv
module flowlet_hop_table
  import flowlet_pkg::*;
#(
  parameter int unsigned ENTRIES   = DEF_ENTRIES,
  parameter int unsigned PORT_W    = DEF_PORT_W,
  parameter int unsigned TS_W      = DEF_TS_W,
  parameter int unsigned HOP_W     = DEF_HOP_W,
  parameter int unsigned GAP_LIMIT = DEF_GAP_LIMIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PORT_W-1:0] in_src_port,
  input  logic [PORT_W-1:0] in_dst_port,
  input  logic [TS_W-1:0]   in_arrival,
  input  logic [HOP_W-1:0]  in_new_hop,
  output logic              out_valid,
  output logic [HOP_W-1:0]  out_hop
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] entry_idx;
  logic [TS_W-1:0]  stored_time;
  logic [HOP_W-1:0] stored_hop;
  logic             take_new;
  logic             hop_write;
  logic [HOP_W-1:0] chosen_hop;

  flowlet_index_hash #(.PORT_W(PORT_W), .ENTRIES(ENTRIES)) u_hash (
    .src_port (in_src_port),
    .dst_port (in_dst_port),
    .index    (entry_idx)
  );

  flowlet_gap_decide #(.TS_W(TS_W), .HOP_W(HOP_W), .GAP_LIMIT(GAP_LIMIT)) u_decide (
    .arrival      (in_arrival),
    .last_time    (stored_time),
    .stored_hop   (stored_hop),
    .proposed_hop (in_new_hop),
    .take_new     (take_new),
    .chosen_hop   (chosen_hop)
  );

  assign hop_write = in_valid && take_new;

  flowlet_state_store #(.ENTRIES(ENTRIES), .TS_W(TS_W), .HOP_W(HOP_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_idx (entry_idx),
    .rd_time (stored_time),
    .rd_hop  (stored_hop),
    .time_we (in_valid),
    .wr_time (in_arrival),
    .hop_we  (hop_write),
    .wr_hop  (in_new_hop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hop   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_hop <= chosen_hop;
    end
  end

  // R2: one result per packet, one cycle later.
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: an expired entry hands out the proposed hop.
  assert_new_hop_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hop_write |=> out_hop == $past(in_new_hop));

  // R4: a live entry hands out its stored hop.
  assert_kept_hop_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !take_new) |=> out_hop == $past(stored_hop));

  // R7: reset leaves no result pending.
  assert_reset_quiet_R7: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/flowlet_hop_table_tb_top.sv
module flowlet_hop_table_tb_top;
  localparam int unsigned LIMIT = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_src_port = '0;
  logic [15:0] in_dst_port = '0;
  logic [31:0] in_arrival = '0;
  logic [7:0]  in_new_hop = '0;
  logic        out_valid;
  logic [7:0]  out_hop;

  int checks = 0;
  int errors = 0;

  // Bench-side view of the table, built from the requirements.
  logic [31:0] m_time [64];
  logic [7:0]  m_hop  [64];

  always #2 clk = ~clk;

  flowlet_hop_table dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_src_port(in_src_port), .in_dst_port(in_dst_port),
    .in_arrival(in_arrival), .in_new_hop(in_new_hop),
    .out_valid(out_valid), .out_hop(out_hop)
  );

  // R1: bit b of the index collects key bits whose position mod 6 is b.
  function automatic int unsigned key_index(input logic [15:0] s, input logic [15:0] d);
    logic [31:0] key;
    logic [5:0]  idx;
    key = {s, d};
    idx = '0;
    for (int k = 0; k < 32; k++) idx[k % 6] = idx[k % 6] ^ key[k];
    return int'(idx);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one packet on a falling edge, check its result one edge later.
  task automatic send(input string req, input logic [15:0] s, input logic [15:0] d,
                      input logic [31:0] t, input logic [7:0] h);
    int unsigned i;
    logic [31:0] gap;
    logic [7:0]  exp_hop;
    i   = key_index(s, d);
    gap = t - m_time[i];
    if (gap > LIMIT) m_hop[i] = h;
    exp_hop   = m_hop[i];
    m_time[i] = t;
    in_valid = 1'b1; in_src_port = s; in_dst_port = d; in_arrival = t; in_new_hop = h;
    @(negedge clk);
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " hop"}, 32'(out_hop), 32'(exp_hop));
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int c = 0; c < n; c++) begin
      in_new_hop = 8'hEE; in_arrival = 32'hFFFF_0000;
      @(negedge clk);
      check("R2 idle valid", 32'(out_valid), 32'd0);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 64; i++) begin m_time[i] = '0; m_hop[i] = '0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 reset valid", 32'(out_valid), 32'd0);
    check("R7 reset hop", 32'(out_hop), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // Gap 50 from a cleared time of zero: stored hop zero must come out.
    send("R7 cleared entry", 16'h0003, 16'h0000, 32'd50, 8'h07);
    idle(1);
  endtask

  task automatic t_threshold();
    send("R3 first expiry", 16'h0000, 16'h0005, 32'd1000, 8'h11);
    send("R4 equal gap kept", 16'h0000, 16'h0005, 32'd1100, 8'h22);
    send("R4 small gap kept", 16'h0000, 16'h0005, 32'd1150, 8'h33);
    send("R3 gap one over", 16'h0000, 16'h0005, 32'd1251, 8'h44);
    idle(2);
  endtask

  task automatic t_writeback();
    // Times refresh on every hit, so steady traffic never expires (R5).
    for (int n = 1; n <= 4; n++)
      send("R5 refresh keeps", 16'h0000, 16'h0009, 32'd5000 + 32'(n * 90), 8'(8'h50 + n));
    send("R5 last time used", 16'h0000, 16'h0009, 32'd5360 + 32'd101, 8'h5F);
    idle(1);
  endtask

  task automatic t_alias();
    // 0001_0000 folds to bit 4 (key bit 16), as does 0000_0010 (key bit 4).
    send("R1 alias first", 16'h0001, 16'h0000, 32'd20000, 8'h61);
    send("R1 alias shares", 16'h0000, 16'h0010, 32'd20040, 8'h62);
    send("R1 distinct entry", 16'h0000, 16'h0001, 32'd20050, 8'h63);
    check("R1 index model", 32'(key_index(16'h0001, 16'h0000)), 32'd16);
    idle(1);
  endtask

  task automatic t_back_to_back();
    send("R6 b2b first", 16'h1234, 16'h5678, 32'd30000, 8'h71);
    send("R6 b2b same", 16'h1234, 16'h5678, 32'd30001, 8'h72);
    send("R6 b2b other", 16'h4321, 16'h8765, 32'd30002, 8'h73);
    send("R6 b2b expire", 16'h1234, 16'h5678, 32'd30102, 8'h74);
    send("R6 b2b after", 16'h1234, 16'h5678, 32'd30103, 8'h75);
    idle(1);
  endtask

  task automatic t_wrap();
    send("R8 near top", 16'h00AA, 16'h0000, 32'hFFFF_FFC0, 8'h81);
    send("R8 wrapped small", 16'h00AA, 16'h0000, 32'h0000_0020, 8'h82);
    send("R8 wrapped large", 16'h00AA, 16'h0000, 32'h0000_0100, 8'h83);
    idle(1);
  endtask

  task automatic t_isolation();
    send("R9 setup", 16'h0000, 16'h0030, 32'd40000, 8'h91);
    idle(5);
    // Idle cycles carried time FFFF0000; had it been written the gap would differ.
    send("R9 idle no write", 16'h0000, 16'h0030, 32'd40080, 8'h92);
    send("R9 other untouched", 16'h0000, 16'h0005, 32'd1300, 8'h93);
    idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_threshold();
    t_writeback();
    t_alias();
    t_back_to_back();
    t_wrap();
    t_isolation();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule